// File: doc/BRIEF.md
# Virtual Interrupt List Register Bank

A small bank of list entries through which a host hands virtual interrupts to a guest CPU interface. Each entry holds a virtual interrupt ID, a two-bit state, a flag that links the entry to a physical interrupt, and the ID of that physical interrupt. The host programs and inspects entries through a register port. The guest takes interrupts through an acknowledge port and completes them through a deactivate port.

When the guest deactivates a linked entry, the bank sends a one-cycle pulse carrying the physical ID, so the physical interrupt can be released as well. A linked entry may hold pending or active, but never both. The bank rejects a host write that asks for both on a linked entry. An empty vector with one bit per entry tells the host which entries are free to reuse.

Top module: `vlr_bank`

## Requirements
- R1: After reset every entry reads state 0, link flag 0, virtual ID 0 and physical ID 0. The empty vector is all ones and no physical-deactivate pulse is driven.
- R2: A host write stores virtual ID, state, link flag and physical ID into entry `host_idx` at the clock edge. The read outputs show entry `host_idx` combinationally. State encoding: 0 inactive, 1 pending, 2 active, 3 pending-and-active.
- R3: A host write with the link flag set and state 3 is rejected, and the addressed entry keeps its previous contents.
- R4: While `ack_req` is high, `ack_vid` shows the virtual ID of the lowest-index entry whose pending bit is set. At the clock edge that entry clears pending and sets active, so state 1 becomes 2 and state 3 becomes 2.
- R5: An acknowledge with no pending entry returns all ones in `ack_vid` and changes no entry.
- R6: A deactivate whose ID matches an active entry clears that entry's active bit. Only the lowest-index match is affected. An entry in state 2 becomes inactive, and an unlinked entry in state 3 becomes pending.
- R7: A deactivate that hits a linked entry raises `pdeact_valid` for exactly one cycle, starting in the cycle after the request, with `pdeact_pid` equal to that entry's physical ID.
- R8: A deactivate that matches no active entry changes no entry and produces no pulse.
- R9: Empty bit i is 1 exactly when entry i is in state 0.
- R10: A linked entry that has gone inactive keeps its link flag, virtual ID and physical ID until the host rewrites it.
- R11: In the same cycle, an acknowledge and a deactivate on different entries both take effect. A host write to an entry takes priority over any guest operation on that same entry in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_idx | input | IDX_W | Entry addressed for write and read |
| host_wvid | input | VID_W | Virtual ID to write |
| host_wstate | input | 2 | State to write |
| host_whw | input | 1 | Link flag to write |
| host_wpid | input | PID_W | Physical ID to write |
| host_rvid | output | VID_W | Virtual ID of the addressed entry |
| host_rstate | output | 2 | State of the addressed entry |
| host_rhw | output | 1 | Link flag of the addressed entry |
| host_rpid | output | PID_W | Physical ID of the addressed entry |
| ack_req | input | 1 | Guest acknowledge |
| ack_vid | output | VID_W | Acknowledged virtual ID, or all ones when nothing is pending |
| eoi_req | input | 1 | Guest deactivate |
| eoi_vid | input | VID_W | Virtual ID to deactivate |
| pdeact_valid | output | 1 | Physical-deactivate pulse |
| pdeact_pid | output | PID_W | Physical ID carried by the pulse |
| empty | output | N | One bit per entry, 1 when the entry is inactive |

## Verification
Acknowledge and deactivate can fall in the same cycle. The bench provokes this by raising both requests in one cycle. The acknowledge picks a pending unlinked entry, and the deactivate names a different, active linked entry. The bench then reads back both states, checks the acknowledged ID, and checks that exactly one physical pulse appears through the scoreboard queue. A second collision puts a host write on the entry that a deactivate is completing in the same cycle, and the read-back must show the written contents.

// File: rtl/vlr_bank.sv
module vlr_bank #(
  parameter int N     = 4,
  parameter int VID_W = 10,
  parameter int PID_W = 10,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [VID_W-1:0] host_wvid,
  input  logic [1:0]       host_wstate,
  input  logic             host_whw,
  input  logic [PID_W-1:0] host_wpid,
  output logic [VID_W-1:0] host_rvid,
  output logic [1:0]       host_rstate,
  output logic             host_rhw,
  output logic [PID_W-1:0] host_rpid,
  input  logic             ack_req,
  output logic [VID_W-1:0] ack_vid,
  input  logic             eoi_req,
  input  logic [VID_W-1:0] eoi_vid,
  output logic             pdeact_valid,
  output logic [PID_W-1:0] pdeact_pid,
  output logic [N-1:0]     empty
);

  logic [N-1:0][VID_W-1:0] vid_q;
  logic [N-1:0][PID_W-1:0] pid_q;
  logic [N-1:0][1:0]       st_q;
  logic [N-1:0]            hw_q;

  logic [N-1:0] ack_sel, eoi_sel;
  logic         eoi_hw;
  logic [PID_W-1:0] eoi_pid;
  logic         wr_ok;

  assign wr_ok = host_we && !(host_whw && host_wstate == 2'b11);

  always_comb begin
    logic found_a, found_e;
    found_a = 1'b0;
    found_e = 1'b0;
    ack_sel = '0;
    eoi_sel = '0;
    ack_vid = '1;
    eoi_hw  = 1'b0;
    eoi_pid = '0;
    for (int i = 0; i < N; i++) begin
      if (!found_a && st_q[i][0]) begin
        found_a    = 1'b1;
        ack_sel[i] = ack_req;
        ack_vid    = vid_q[i];
      end
      if (!found_e && eoi_req && st_q[i][1] && vid_q[i] == eoi_vid) begin
        found_e    = 1'b1;
        eoi_sel[i] = 1'b1;
        eoi_hw     = hw_q[i];
        eoi_pid    = pid_q[i];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vid_q[i] <= '0;
        pid_q[i] <= '0;
        st_q[i]  <= 2'b00;
        hw_q[i]  <= 1'b0;
      end else if (wr_ok && host_idx == IDX_W'(i)) begin
        vid_q[i] <= host_wvid;
        pid_q[i] <= host_wpid;
        st_q[i]  <= host_wstate;
        hw_q[i]  <= host_whw;
      end else begin
        st_q[i][0] <= st_q[i][0] & ~ack_sel[i];
        st_q[i][1] <= (st_q[i][1] & ~eoi_sel[i]) | ack_sel[i];
      end
    end
    assign empty[i] = (st_q[i] == 2'b00);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pdeact_valid <= 1'b0;
      pdeact_pid   <= '0;
    end else begin
      pdeact_valid <= |eoi_sel && eoi_hw;
      pdeact_pid   <= eoi_pid;
    end
  end

  assign host_rvid   = vid_q[host_idx];
  assign host_rstate = st_q[host_idx];
  assign host_rhw    = hw_q[host_idx];
  assign host_rpid   = pid_q[host_idx];

endmodule

// File: rtl/vlr_bank_chk.sv
module vlr_bank_chk #(
  parameter int N     = 4,
  parameter int VID_W = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    host_we,
  input logic                    ack_req,
  input logic [VID_W-1:0]        ack_vid,
  input logic                    eoi_req,
  input logic [VID_W-1:0]        eoi_vid,
  input logic                    pdeact_valid,
  input logic [N-1:0]            empty,
  input logic [N-1:0][1:0]       st,
  input logic [N-1:0]            hw,
  input logic [N-1:0][VID_W-1:0] vid
);

  logic [N-1:0] pend, hit;
  for (genvar i = 0; i < N; i++) begin : g_m
    assign pend[i] = st[i][0];
    assign hit[i]  = st[i][1] && vid[i] == eoi_vid;

    a_r3_linked_never_both: assert property (@(posedge clk) disable iff (!rst_n)
      !(hw[i] && st[i] == 2'b11));
  end

  a_r7_pulse_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
    pdeact_valid |-> $past(eoi_req));

  a_r5_spurious_id: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && pend == '0) |-> ack_vid == '1);

  a_r8_no_match_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_req && hit == '0) |=> !pdeact_valid);

  a_r9_ack_keeps_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !host_we && !eoi_req) |=> $stable(empty));

endmodule

bind vlr_bank vlr_bank_chk #(.N(N), .VID_W(VID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .ack_req(ack_req),
  .ack_vid(ack_vid), .eoi_req(eoi_req), .eoi_vid(eoi_vid),
  .pdeact_valid(pdeact_valid), .empty(empty), .st(st_q), .hw(hw_q), .vid(vid_q)
);

// File: tb/vlr_bank_bench.sv
`timescale 1ns/1ps
module vlr_bank_bench;
  localparam int N = 4, VID_W = 10, PID_W = 10, IDX_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 0;
  logic [IDX_W-1:0] host_idx = '0;
  logic [VID_W-1:0] host_wvid = '0;
  logic [1:0] host_wstate = '0;
  logic host_whw = 0;
  logic [PID_W-1:0] host_wpid = '0;
  logic [VID_W-1:0] host_rvid;
  logic [1:0] host_rstate;
  logic host_rhw;
  logic [PID_W-1:0] host_rpid;
  logic ack_req = 0;
  logic [VID_W-1:0] ack_vid;
  logic eoi_req = 0;
  logic [VID_W-1:0] eoi_vid = '0;
  logic pdeact_valid;
  logic [PID_W-1:0] pdeact_pid;
  logic [N-1:0] empty;

  int vectors = 0, errors = 0;
  logic [PID_W-1:0] exp_q[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  vlr_bank #(.N(N), .VID_W(VID_W), .PID_W(PID_W)) u_vlr_bank (.*);

  task automatic cmp(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (pdeact_valid) begin
      if (exp_q.size() == 0) begin
        vectors++; errors++;
        $display("FAIL R8 unexpected pulse: got pid %0d expected none", pdeact_pid);
      end else cmp("R7 pulse pid", pdeact_pid, exp_q.pop_front());
    end
  end

  task automatic finish_cycle();
    @(posedge clk); #1;
    host_we = 0; ack_req = 0; eoi_req = 0;
  endtask

  task automatic wr(int idx, int v, int s, int h, int p);
    @(negedge clk);
    host_we = 1; host_idx = IDX_W'(idx); host_wvid = VID_W'(v);
    host_wstate = 2'(s); host_whw = h[0]; host_wpid = PID_W'(p);
    finish_cycle();
  endtask

  task automatic rd(string tag, int idx, int v, int s, int h, int p);
    @(negedge clk);
    host_idx = IDX_W'(idx); #1;
    cmp({tag, " vid"}, host_rvid, v);
    cmp({tag, " state"}, host_rstate, s);
    cmp({tag, " link"}, host_rhw, h);
    cmp({tag, " pid"}, host_rpid, p);
  endtask

  task automatic ack(string tag, int exp_v);
    @(negedge clk);
    ack_req = 1; #1;
    cmp(tag, ack_vid, exp_v);
    finish_cycle();
  endtask

  task automatic eoi(int v, bit pulse, int p);
    @(negedge clk);
    if (pulse) exp_q.push_back(PID_W'(p));
    eoi_req = 1; eoi_vid = VID_W'(v);
    finish_cycle();
  endtask

  task automatic chk_empty(string tag, int exp);
    @(negedge clk); #1;
    cmp(tag, empty, exp);
  endtask

  initial begin
    #200000;
    vectors++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk_empty("R1 empty after reset", 4'b1111);
    cmp("R1 no pulse after reset", pdeact_valid, 0);
    rd("R1 entry0 after reset", 0, 0, 0, 0, 0);

    wr(0, 5, 1, 1, 33);
    wr(1, 7, 1, 0, 0);
    wr(2, 9, 3, 0, 0);
    rd("R2 entry0 readback", 0, 5, 1, 1, 33);
    rd("R2 entry2 readback", 2, 9, 3, 0, 0);
    chk_empty("R9 empty with three busy", 4'b1000);

    wr(3, 12, 3, 1, 40);
    rd("R3 rejected write to free entry", 3, 0, 0, 0, 0);
    wr(0, 99, 3, 1, 50);
    rd("R3 rejected write keeps entry0", 0, 5, 1, 1, 33);

    ack("R4 lowest pending first", 5);
    rd("R4 entry0 now active", 0, 5, 2, 1, 33);
    ack("R4 next pending", 7);
    ack("R4 pending-and-active entry", 9);
    rd("R4 entry2 now active", 2, 9, 2, 0, 0);
    ack("R5 spurious id", 10'h3FF);
    chk_empty("R5 no change after spurious", 4'b1000);

    eoi(100, 0, 0);
    chk_empty("R8 unmatched deactivate ignored", 4'b1000);

    eoi(5, 1, 33);
    chk_empty("R9 entry0 empty after deactivate", 4'b1001);
    rd("R10 linked entry keeps link and pid", 0, 5, 0, 1, 33);

    wr(2, 9, 3, 0, 0);
    eoi(9, 0, 0);
    rd("R6 pending-and-active returns to pending", 2, 9, 1, 0, 0);
    eoi(7, 0, 0);
    rd("R6 active returns to inactive", 1, 7, 0, 0, 0);

    wr(0, 5, 2, 1, 33);
    @(negedge clk);
    exp_q.push_back(PID_W'(33));
    ack_req = 1; eoi_req = 1; eoi_vid = 5; #1;
    cmp("R11 ack alongside deactivate", ack_vid, 9);
    finish_cycle();
    rd("R11 acked entry active", 2, 9, 2, 0, 0);
    rd("R11 deactivated entry inactive", 0, 5, 0, 1, 33);

    @(negedge clk);
    host_we = 1; host_idx = 2; host_wvid = 20; host_wstate = 1; host_whw = 0; host_wpid = 0;
    eoi_req = 1; eoi_vid = 9;
    finish_cycle();
    rd("R11 host write wins over deactivate", 2, 20, 1, 0, 0);

    wr(1, 30, 1, 0, 0);
    ack("R4 lower index wins among two pending", 30);
    ack("R4 remaining pending", 20);

    repeat (3) @(negedge clk);
    cmp("R7 all pulses seen", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule